// File: doc/BRIEF.md
# Bank-Partitioned Two-Way Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a 32-bit virtual address space with 512-byte pages. It has two ways (banks) of 64 sets each. The set index is built from the system/process address bit and the five lowest page-number bits. System translations therefore always sit in the upper 32 sets of each way, and process translations sit in the lower 32. A context switch pulses one input that clears only the process half. Every entry held for the system is left in place.

A lookup carries a virtual address, a read/write flag and one of four privilege levels. The lookup returns one cycle later with the 30-bit physical address and a trap code: no trap, TLB miss, protection violation or page fault. It also returns a request to set the page's modify bit. Each entry holds a 4-bit protection code. A programmable table of 2-bit rights maps each pair of code and privilege level to what that level may do. Entries are written through a fill port. The fill port picks the way itself: it reuses a way that already holds the page, then takes an empty way, and otherwise takes the way not used most recently in that set.

The lookup request and the response are valid/ready streams. A request is taken on any clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is high whenever the response register is empty or being drained. A pending response holds all of its fields until `rsp_ready` accepts it. Fill, flush and configuration are plain single-cycle strobes with no back-pressure. Their effects are visible to any lookup accepted on a later edge.

Top module: `tlb_two_way`

## Requirements
- R1: The set index is {va[31], va[13:9]} and the tag is va[30:14]. On a translation without trap, rsp_paddr = {frame number of the matching entry, va[8:0]}.
- R2: When no way holds a valid entry whose tag matches at the addressed set, rsp_trap = 1 (miss). After reset every lookup misses.
- R3: The rights for a (code, level) pair are 2 bits: bit 0 allows reads and bit 1 allows writes. Levels are 0 kernel, 1 executive, 2 supervisor and 3 user. After reset, code 4'b1001 gives kernel and executive both rights (11), supervisor read only (01) and user nothing (00), and every other code gives 00 to every level. A hit whose access is not allowed returns rsp_trap = 2 (protection).
- R4: A configuration write replaces the rights of one (code, level) pair. The new rights apply to lookups accepted after that write's edge and leave all other pairs unchanged.
- R5: A hit that passes the protection check but whose present bit is 0 returns rsp_trap = 3 (page fault). The priority is miss, then protection, then page fault, and trap 0 means a clean translation.
- R6: rsp_mod_req is 1 only for a clean write translation whose entry has its modify bit at 0. It is 0 for reads, for writes to entries already modified, and for any trap.
- R7: A flush pulse invalidates every entry with va[31] = 0 in both ways and leaves every entry with va[31] = 1 valid.
- R8: A fill writes the way that already matches its address. If no way matches, it writes way 0 if that way is empty, else way 1 if that way is empty, else the way that was not most recently used in that set. Both fills and lookup hits mark a way as most recently used.
- R9: At most one way matches any lookup, so refilling a page that is already held replaces its contents.
- R10: A request accepted on an edge produces rsp_valid = 1 after that edge. While rsp_valid = 1 and rsp_ready = 0, req_ready = 0 and all response fields hold their values.
- R11: During and right after reset, rsp_valid = 0 and req_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_priv | input | 2 | Privilege level (0 kernel ... 3 user) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_paddr | output | 30 | Physical address |
| rsp_trap | output | 2 | 0 none, 1 miss, 2 protection, 3 page fault |
| rsp_mod_req | output | 1 | Request to set the page's modify bit |
| fill_valid | input | 1 | Write one entry this cycle |
| fill_vaddr | input | 32 | Virtual address giving the fill set and tag |
| fill_pfn | input | 21 | Physical frame number |
| fill_prot | input | 4 | Protection code |
| fill_present | input | 1 | Page is in memory |
| fill_modify | input | 1 | Page already modified |
| flush_proc | input | 1 | Invalidate all process entries |
| cfg_we | input | 1 | Rights table write strobe |
| cfg_code | input | 4 | Protection code to program |
| cfg_priv | input | 2 | Privilege level to program |
| cfg_rights | input | 2 | Rights value (bit 0 read, bit 1 write) |

## Verification
On every cycle, the assertions check four things. No more than one way matches a lookup or a fill address. A flush leaves no live process entry and does not touch the system entries. A stalled response stays frozen, and a modify request never travels with a trap. The bench scenarios show the end-to-end behaviour: the address layout, the protection and page-fault priority, the reset contents and reprogramming of the rights table, and which way a fill replaces after a given order of fills and hits.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_MISS  = 2'd1,
    TRAP_PROT  = 2'd2,
    TRAP_FAULT = 2'd3
  } trap_e;

  localparam int RIGHT_RD = 0;
  localparam int RIGHT_WR = 1;
endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int SET_W  = 6,
  parameter int TAG_W  = 17,
  parameter int PFN_W  = 21,
  parameter int PROT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_proc,
  input  logic [SET_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PROT_W-1:0] lk_prot,
  output logic              lk_present,
  output logic              lk_modify,
  input  logic [SET_W-1:0]  fl_idx,
  output logic              fl_valid,
  output logic [TAG_W-1:0]  fl_tag,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PROT_W-1:0] wr_prot,
  input  logic              wr_present,
  input  logic              wr_modify
);
  localparam int SETS   = 1 << SET_W;
  localparam int HALF   = SETS / 2;
  localparam int DATA_W = TAG_W + PFN_W + PROT_W + 2;

  logic [SETS-1:0]   valid_q;
  logic [DATA_W-1:0] data_q [SETS];
  logic [DATA_W-1:0] lk_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (wr_en && fl_idx == SET_W'(s))
          valid_q[s] <= 1'b1;
        else if (flush_proc && s < HALF)
          valid_q[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      data_q[fl_idx] <= {wr_tag, wr_pfn, wr_prot, wr_present, wr_modify};
  end

  assign lk_word  = data_q[lk_idx];
  assign lk_valid = valid_q[lk_idx];
  assign {lk_tag, lk_pfn, lk_prot, lk_present, lk_modify} = lk_word;
  assign fl_valid = valid_q[fl_idx];
  assign fl_tag   = data_q[fl_idx][DATA_W-1 -: TAG_W];

  // R7
  flush_clears_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_proc && !(wr_en && !fl_idx[SET_W-1])) |=> (valid_q[HALF-1:0] == '0));

  // R7
  flush_keeps_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_proc && !wr_en) |=> $stable(valid_q[SETS-1:HALF]));
endmodule

// File: rtl/tlb_prot_table.sv
module tlb_prot_table #(
  parameter int CODE_W   = 4,
  parameter int LVL_W    = 2,
  parameter int DEF_CODE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic [LVL_W-1:0]  cfg_lvl,
  input  logic [1:0]        cfg_rights,
  input  logic [CODE_W-1:0] rd_code,
  input  logic [LVL_W-1:0]  rd_lvl,
  output logic [1:0]        rd_rights
);
  localparam int ENTRIES = 1 << (CODE_W + LVL_W);
  localparam int LVLS    = 1 << LVL_W;

  logic [1:0] rights_q [ENTRIES];

  function automatic logic [1:0] reset_rights(input int i);
    int code, lvl;
    code = i / LVLS;
    lvl  = i % LVLS;
    if (code != DEF_CODE) return 2'b00;
    case (lvl)
      0, 1:    return 2'b11;
      2:       return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) rights_q[i] <= reset_rights(i);
    end else if (cfg_we) begin
      rights_q[{cfg_code, cfg_lvl}] <= cfg_rights;
    end
  end

  assign rd_rights = rights_q[{rd_code, rd_lvl}];
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [SET_W-1:0] hit_idx,
  input  logic             hit_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_idx,
  input  logic [1:0]       fill_valid,
  input  logic [1:0]       fill_match,
  output logic             victim_way
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] mru_q;

  always_comb begin
    if (|fill_match)        victim_way = fill_match[1];
    else if (!fill_valid[0]) victim_way = 1'b0;
    else if (!fill_valid[1]) victim_way = 1'b1;
    else                     victim_way = ~mru_q[fill_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mru_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (fill_en && fill_idx == SET_W'(s))
          mru_q[s] <= victim_way;
        else if (hit_en && hit_idx == SET_W'(s))
          mru_q[s] <= hit_way;
      end
    end
  end

  // R9
  fill_match_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> $onehot0(fill_match));
endmodule

// File: rtl/tlb_two_way.sv
module tlb_two_way #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 9,
  parameter int SET_W  = 6,
  parameter int PFN_W  = 21,
  parameter int PROT_W = 4,
  parameter int LVL_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  input  logic [LVL_W-1:0]       req_priv,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic [1:0]             rsp_trap,
  output logic                   rsp_mod_req,
  input  logic                   fill_valid,
  input  logic [VA_W-1:0]        fill_vaddr,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic [PROT_W-1:0]      fill_prot,
  input  logic                   fill_present,
  input  logic                   fill_modify,
  input  logic                   flush_proc,
  input  logic                   cfg_we,
  input  logic [PROT_W-1:0]      cfg_code,
  input  logic [LVL_W-1:0]       cfg_priv,
  input  logic [1:0]             cfg_rights
);
  import tlb_pkg::*;

  localparam int WAYS  = 2;
  localparam int LOW_W = SET_W - 1;
  localparam int TAG_W = VA_W - 1 - OFF_W - LOW_W;
  localparam int PA_W  = PFN_W + OFF_W;

  logic [SET_W-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0] lk_tag_in, fl_tag_in;

  assign lk_idx    = {req_vaddr[VA_W-1], req_vaddr[OFF_W +: LOW_W]};
  assign fl_idx    = {fill_vaddr[VA_W-1], fill_vaddr[OFF_W +: LOW_W]};
  assign lk_tag_in = req_vaddr[VA_W-2 -: TAG_W];
  assign fl_tag_in = fill_vaddr[VA_W-2 -: TAG_W];

  logic [WAYS-1:0]   w_valid, w_present, w_modify, w_fvalid, w_we;
  logic [TAG_W-1:0]  w_tag   [WAYS];
  logic [TAG_W-1:0]  w_ftag  [WAYS];
  logic [PFN_W-1:0]  w_pfn   [WAYS];
  logic [PROT_W-1:0] w_prot  [WAYS];
  logic [WAYS-1:0]   hit_vec, fill_match;
  logic              victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign w_we[w]       = fill_valid && (victim == w[0]);
    assign hit_vec[w]    = w_valid[w] && (w_tag[w] == lk_tag_in);
    assign fill_match[w] = w_fvalid[w] && (w_ftag[w] == fl_tag_in);

    tlb_way #(
      .SET_W(SET_W), .TAG_W(TAG_W), .PFN_W(PFN_W), .PROT_W(PROT_W)
    ) u_way (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_proc (flush_proc),
      .lk_idx     (lk_idx),
      .lk_valid   (w_valid[w]),
      .lk_tag     (w_tag[w]),
      .lk_pfn     (w_pfn[w]),
      .lk_prot    (w_prot[w]),
      .lk_present (w_present[w]),
      .lk_modify  (w_modify[w]),
      .fl_idx     (fl_idx),
      .fl_valid   (w_fvalid[w]),
      .fl_tag     (w_ftag[w]),
      .wr_en      (w_we[w]),
      .wr_tag     (fl_tag_in),
      .wr_pfn     (fill_pfn),
      .wr_prot    (fill_prot),
      .wr_present (fill_present),
      .wr_modify  (fill_modify)
    );
  end

  logic accept;
  logic hit, sel;
  assign accept = req_valid && req_ready;
  assign hit    = |hit_vec;
  assign sel    = hit_vec[1];

  tlb_victim #(.SET_W(SET_W)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_en     (accept && hit),
    .hit_idx    (lk_idx),
    .hit_way    (sel),
    .fill_en    (fill_valid),
    .fill_idx   (fl_idx),
    .fill_valid (w_fvalid),
    .fill_match (fill_match),
    .victim_way (victim)
  );

  logic [1:0] rights;
  tlb_prot_table #(.CODE_W(PROT_W), .LVL_W(LVL_W)) u_prot (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_code   (cfg_code),
    .cfg_lvl    (cfg_priv),
    .cfg_rights (cfg_rights),
    .rd_code    (w_prot[sel]),
    .rd_lvl     (req_priv),
    .rd_rights  (rights)
  );

  logic    allowed;
  trap_e   trap_d;
  logic    mod_d;
  always_comb begin
    allowed = req_write ? rights[RIGHT_WR] : rights[RIGHT_RD];
    if (!hit)                 trap_d = TRAP_MISS;
    else if (!allowed)        trap_d = TRAP_PROT;
    else if (!w_present[sel]) trap_d = TRAP_FAULT;
    else                      trap_d = TRAP_NONE;
    mod_d = (trap_d == TRAP_NONE) && req_write && !w_modify[sel];
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_trap    <= TRAP_NONE;
      rsp_mod_req <= 1'b0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_paddr   <= {w_pfn[sel], req_vaddr[OFF_W-1:0]};
      rsp_trap    <= trap_d;
      rsp_mod_req <= mod_d;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

  // R9
  way_match_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
                                   $stable(rsp_trap) && $stable(rsp_mod_req)));

  // R10
  accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R6
  mod_req_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mod_req) |-> (rsp_trap == TRAP_NONE));

  localparam int PA_CHK = PA_W;
endmodule

// File: tb/tb_tlb_two_way.sv
module tb_tlb_two_way;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_vaddr;
  logic [1:0]  req_priv;
  logic        rsp_valid, rsp_ready, rsp_mod_req;
  logic [29:0] rsp_paddr;
  logic [1:0]  rsp_trap;
  logic        fill_valid, fill_present, fill_modify;
  logic [31:0] fill_vaddr;
  logic [20:0] fill_pfn;
  logic [3:0]  fill_prot;
  logic        flush_proc, cfg_we;
  logic [3:0]  cfg_code;
  logic [1:0]  cfg_priv, cfg_rights;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tlb_two_way dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_trap(rsp_trap), .rsp_mod_req(rsp_mod_req),
    .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_pfn(fill_pfn),
    .fill_prot(fill_prot), .fill_present(fill_present), .fill_modify(fill_modify),
    .flush_proc(flush_proc),
    .cfg_we(cfg_we), .cfg_code(cfg_code), .cfg_priv(cfg_priv), .cfg_rights(cfg_rights)
  );

  function automatic logic [31:0] mk_va(input logic sys, input logic [16:0] tag,
                                        input logic [4:0] low, input logic [8:0] off);
    return {sys, tag, low, off};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic fill(input logic [31:0] va, input logic [20:0] pfn, input logic [3:0] prot,
                      input logic present, input logic modify);
    @(negedge clk);
    fill_valid = 1'b1; fill_vaddr = va; fill_pfn = pfn; fill_prot = prot;
    fill_present = present; fill_modify = modify;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic program_rights(input logic [3:0] code, input logic [1:0] lvl,
                                input logic [1:0] r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_code = code; cfg_priv = lvl; cfg_rights = r;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic wr, input logic [1:0] lvl);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_priv = lvl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic [1:0] trap,
                            input logic [29:0] pa, input logic mod);
    chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "trap", 32'(rsp_trap), 32'(trap));
    if (trap == 2'd0) chk(req, "paddr", 32'(rsp_paddr), 32'(pa));
    chk(req, "mod_req", 32'(rsp_mod_req), 32'(mod));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R11", "req_ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    lookup(mk_va(1'b0, 17'h00123, 5'd3, 9'h010), 1'b0, 2'd0);
    expect_rsp("R2", 2'd1, '0, 1'b0);
    lookup(mk_va(1'b1, 17'h1FFFF, 5'd31, 9'h1FF), 1'b0, 2'd0);
    expect_rsp("R2", 2'd1, '0, 1'b0);
  endtask

  task automatic t_translate;
    fill(mk_va(1'b0, 17'h0ABCD, 5'd5, 9'h000), 21'h12345, 4'd9, 1'b1, 1'b1);
    fill(mk_va(1'b1, 17'h0ABCD, 5'd5, 9'h000), 21'h1F0F0, 4'd9, 1'b1, 1'b1);
    lookup(mk_va(1'b0, 17'h0ABCD, 5'd5, 9'h1A7), 1'b0, 2'd0);
    expect_rsp("R1", 2'd0, {21'h12345, 9'h1A7}, 1'b0);
    lookup(mk_va(1'b1, 17'h0ABCD, 5'd5, 9'h033), 1'b0, 2'd0);
    expect_rsp("R1", 2'd0, {21'h1F0F0, 9'h033}, 1'b0);
    // same set, different tag: miss
    lookup(mk_va(1'b0, 17'h0ABCC, 5'd5, 9'h000), 1'b0, 2'd0);
    expect_rsp("R2", 2'd1, '0, 1'b0);
    // same tag, different set: miss
    lookup(mk_va(1'b0, 17'h0ABCD, 5'd6, 9'h000), 1'b0, 2'd0);
    expect_rsp("R2", 2'd1, '0, 1'b0);
  endtask

  task automatic t_protection;
    logic [31:0] va;
    va = mk_va(1'b0, 17'h0ABCD, 5'd5, 9'h004);
    lookup(va, 1'b1, 2'd1);
    expect_rsp("R3", 2'd0, {21'h12345, 9'h004}, 1'b0);
    lookup(va, 1'b0, 2'd2);
    expect_rsp("R3", 2'd0, {21'h12345, 9'h004}, 1'b0);
    lookup(va, 1'b1, 2'd2);
    expect_rsp("R3", 2'd2, '0, 1'b0);
    lookup(va, 1'b0, 2'd3);
    expect_rsp("R3", 2'd2, '0, 1'b0);
  endtask

  task automatic t_config;
    logic [31:0] va;
    va = mk_va(1'b0, 17'h00777, 5'd9, 9'h020);
    fill(va, 21'h00042, 4'd3, 1'b1, 1'b1);
    lookup(va, 1'b0, 2'd3);
    expect_rsp("R3", 2'd2, '0, 1'b0);
    program_rights(4'd3, 2'd3, 2'b01);
    lookup(va, 1'b0, 2'd3);
    expect_rsp("R4", 2'd0, {21'h00042, 9'h020}, 1'b0);
    lookup(va, 1'b1, 2'd3);
    expect_rsp("R4", 2'd2, '0, 1'b0);
    lookup(va, 1'b0, 2'd0);
    expect_rsp("R4", 2'd2, '0, 1'b0);
  endtask

  task automatic t_fault;
    logic [31:0] va;
    va = mk_va(1'b0, 17'h01111, 5'd12, 9'h000);
    fill(va, 21'h00999, 4'd9, 1'b0, 1'b0);
    lookup(va, 1'b0, 2'd0);
    expect_rsp("R5", 2'd3, '0, 1'b0);
    lookup(va, 1'b1, 2'd3);
    expect_rsp("R5", 2'd2, '0, 1'b0);
    lookup(va, 1'b1, 2'd0);
    expect_rsp("R5", 2'd3, '0, 1'b0);
  endtask

  task automatic t_modify;
    logic [31:0] va;
    va = mk_va(1'b1, 17'h02222, 5'd14, 9'h0F0);
    fill(va, 21'h00ABC, 4'd9, 1'b1, 1'b0);
    lookup(va, 1'b1, 2'd0);
    expect_rsp("R6", 2'd0, {21'h00ABC, 9'h0F0}, 1'b1);
    lookup(va, 1'b0, 2'd0);
    expect_rsp("R6", 2'd0, {21'h00ABC, 9'h0F0}, 1'b0);
    fill(va, 21'h00ABC, 4'd9, 1'b1, 1'b1);
    lookup(va, 1'b1, 2'd0);
    expect_rsp("R6", 2'd0, {21'h00ABC, 9'h0F0}, 1'b0);
  endtask

  task automatic t_replace;
    logic [31:0] a, b, c, d;
    a = mk_va(1'b0, 17'h00001, 5'd7, 9'h000);
    b = mk_va(1'b0, 17'h00002, 5'd7, 9'h000);
    c = mk_va(1'b0, 17'h00003, 5'd7, 9'h000);
    d = mk_va(1'b0, 17'h00004, 5'd7, 9'h000);
    fill(a, 21'h0000A, 4'd9, 1'b1, 1'b1);
    fill(b, 21'h0000B, 4'd9, 1'b1, 1'b1);
    lookup(a, 1'b0, 2'd0);
    expect_rsp("R8", 2'd0, {21'h0000A, 9'h0}, 1'b0);
    fill(c, 21'h0000C, 4'd9, 1'b1, 1'b1);
    lookup(a, 1'b0, 2'd0);
    expect_rsp("R8", 2'd0, {21'h0000A, 9'h0}, 1'b0);
    lookup(b, 1'b0, 2'd0);
    expect_rsp("R8", 2'd1, '0, 1'b0);
    lookup(c, 1'b0, 2'd0);
    expect_rsp("R8", 2'd0, {21'h0000C, 9'h0}, 1'b0);
    fill(d, 21'h0000D, 4'd9, 1'b1, 1'b1);
    lookup(a, 1'b0, 2'd0);
    expect_rsp("R8", 2'd1, '0, 1'b0);
    lookup(d, 1'b0, 2'd0);
    expect_rsp("R8", 2'd0, {21'h0000D, 9'h0}, 1'b0);
    // refill of a held page overwrites its own way only
    fill(c, 21'h000CC, 4'd9, 1'b1, 1'b1);
    lookup(c, 1'b0, 2'd0);
    expect_rsp("R9", 2'd0, {21'h000CC, 9'h0}, 1'b0);
    lookup(d, 1'b0, 2'd0);
    expect_rsp("R9", 2'd0, {21'h0000D, 9'h0}, 1'b0);
  endtask

  task automatic t_flush;
    @(negedge clk);
    flush_proc = 1'b1;
    @(negedge clk);
    flush_proc = 1'b0;
    lookup(mk_va(1'b0, 17'h0ABCD, 5'd5, 9'h000), 1'b0, 2'd0);
    expect_rsp("R7", 2'd1, '0, 1'b0);
    lookup(mk_va(1'b0, 17'h00003, 5'd7, 9'h000), 1'b0, 2'd0);
    expect_rsp("R7", 2'd1, '0, 1'b0);
    lookup(mk_va(1'b1, 17'h0ABCD, 5'd5, 9'h011), 1'b0, 2'd0);
    expect_rsp("R7", 2'd0, {21'h1F0F0, 9'h011}, 1'b0);
    lookup(mk_va(1'b1, 17'h02222, 5'd14, 9'h001), 1'b0, 2'd0);
    expect_rsp("R7", 2'd0, {21'h00ABC, 9'h001}, 1'b0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_priv = 2'd0;
    req_vaddr = mk_va(1'b1, 17'h0ABCD, 5'd5, 9'h055);
    @(negedge clk);
    expect_rsp("R10", 2'd0, {21'h1F0F0, 9'h055}, 1'b0);
    chk("R10", "req_ready while stalled", 32'(req_ready), 32'd0);
    req_vaddr = mk_va(1'b0, 17'h1234, 5'd1, 9'h000);
    repeat (2) @(negedge clk);
    expect_rsp("R10", 2'd0, {21'h1F0F0, 9'h055}, 1'b0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R10", 2'd1, '0, 1'b0);
    @(negedge clk);
    chk("R10", "rsp drained", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0; req_priv = '0;
    rsp_ready = 1'b1; fill_valid = 1'b0; fill_vaddr = '0; fill_pfn = '0; fill_prot = '0;
    fill_present = 1'b0; fill_modify = 1'b0; flush_proc = 1'b0;
    cfg_we = 1'b0; cfg_code = '0; cfg_priv = '0; cfg_rights = '0;
    t_reset();
    t_translate();
    t_protection();
    t_config();
    t_fault();
    t_modify();
    t_replace();
    t_flush();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule